// File: doc/BRIEF.md
# Ten-Source Level Interrupt Controller

This block gathers level-sensitive interrupt requests from ten peripherals and turns them into two CPU-facing request lines: a normal request and a fast request. Each request line from a peripheral is synchronised to the controller clock. A per-source polarity bit can then invert it. A per-source test bit can take its place, so that software can raise any source without the peripheral. The result is the raw status. A source counts as pending when its raw bit is 1 and its enable bit is 1. A per-source routing bit then sends the pending source to one of the two outputs.

Software reaches the block through a plain 32-bit register bus. Reads return data one cycle after the request. The enable mask is never written directly. One offset sets the enable bits written as 1, and another offset clears the enable bits written as 1. Software can therefore change one source without a read-modify-write sequence. Requests are level-triggered, so nothing is latched inside the block. A source stays pending until the peripheral drops its line or software disables the source.

Top module: `intr_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, routing, polarity, test-data and test-select registers are all 0. Both request outputs are low, and reads of these registers return 0.
- R2: The raw status at offset 0x04 is, bit by bit, the selected source XOR the polarity bit at offset 0x24. A polarity bit of 1 makes that source active low.
- R3: A write to offset 0x08 sets the enable bit of each source whose data bit is 1. Enable bits written as 0 keep their value.
- R4: A write to offset 0x0C clears the enable bit of each source whose data bit is 1. Enable bits written as 0 keep their value. Reads of either 0x08 or 0x0C return the current enable mask.
- R5: The routing register at offset 0x14 sends a source to the normal output when its bit is 0 and to the fast output when its bit is 1. Offset 0x00 reads raw AND enable AND NOT routing. Offset 0x18 reads raw AND enable AND routing.
- R6: The output irq_o is high exactly when the value readable at 0x00 is nonzero, and fiq_o is high exactly when the value readable at 0x18 is nonzero. Both outputs are registered and lag the status by one cycle.
- R7: The test-select register at offset 0x20 is per source. A bit of 1 takes that source from the test-data register at offset 0x1C instead of from src_i. A bit of 0 uses src_i and ignores the test bit.
- R8: Sources are level-triggered. A pending bit and the request output it drives fall once the input deasserts or the source is disabled, with no acknowledge.
- R9: Each src_i bit passes through a two-flop synchroniser. A change on src_i shows in the raw status after two rising edges, and on the request output at the third rising edge.
- R10: Offsets with no register, such as 0x10 and 0x28, read as 0. Writes to the status offsets 0x00, 0x04 and 0x18 change no register. Data bits above bit 9 are dropped on writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 10 | Asynchronous level request lines, one per source |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that reset is held low for at least two clock edges before the first access. This ensures that the enable and routing state seen through $past is defined. They also assume that the bus holds bus_sel, bus_wr, bus_addr and bus_wdata steady across the sampling edge. The stimulus meets both assumptions: it keeps reset low for three cycles, and it changes every bus input and src_i only on the falling clock edge. A read or an output check is made only after enough rising edges have passed for a src_i change to get through the synchroniser and the output register.

// File: rtl/intr_pkg.sv
// Package: shared offsets and the register-select type of the interrupt controller.
// Assumes byte offsets on a 32-bit register bus; software decodes these offsets, so they are fixed.
package intr_pkg;

    localparam logic [7:0] OFS_PEND_NORM = 8'h00;
    localparam logic [7:0] OFS_RAW       = 8'h04;
    localparam logic [7:0] OFS_EN_SET    = 8'h08;
    localparam logic [7:0] OFS_EN_CLR    = 8'h0C;
    localparam logic [7:0] OFS_ROUTE     = 8'h14;
    localparam logic [7:0] OFS_PEND_FAST = 8'h18;
    localparam logic [7:0] OFS_TDATA     = 8'h1C;
    localparam logic [7:0] OFS_TSEL      = 8'h20;
    localparam logic [7:0] OFS_POLARITY  = 8'h24;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_PEND_NORM,
        RS_RAW,
        RS_EN_SET,
        RS_EN_CLR,
        RS_ROUTE,
        RS_PEND_FAST,
        RS_TDATA,
        RS_TSEL,
        RS_POLARITY
    } reg_sel_e;

    // Map a byte offset to a register selector; anything unlisted is RS_NONE.
    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_PEND_NORM: return RS_PEND_NORM;
            OFS_RAW:       return RS_RAW;
            OFS_EN_SET:    return RS_EN_SET;
            OFS_EN_CLR:    return RS_EN_CLR;
            OFS_ROUTE:     return RS_ROUTE;
            OFS_PEND_FAST: return RS_PEND_FAST;
            OFS_TDATA:     return RS_TDATA;
            OFS_TSEL:      return RS_TSEL;
            OFS_POLARITY:  return RS_POLARITY;
            default:       return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/intr_sync.sv
// Module: multi-stage flop synchroniser for a vector of level signals.
// Assumes each bit is an independent slow level; no bus coherency is needed across bits.
module intr_sync #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/intr_regs.sv
// Module: register file of the interrupt controller: enable set/clear, routing,
// polarity, test data, test select, and the registered read-data mux.
// Assumes bus inputs are stable at the rising edge; a read returns data one cycle later.
module intr_regs #(
    parameter int unsigned N_SRC  = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  raw_stat,
    input  logic [N_SRC-1:0]  pend_norm,
    input  logic [N_SRC-1:0]  pend_fast,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC-1:0]  route_q,
    output logic [N_SRC-1:0]  pol_q,
    output logic [N_SRC-1:0]  tdata_q,
    output logic [N_SRC-1:0]  tsel_q
);
    import intr_pkg::*;

    localparam int unsigned PAD_W = DATA_W - N_SRC;

    reg_sel_e         sel;
    logic [N_SRC-1:0] wd;
    logic             wr_hit;
    logic [N_SRC-1:0] rd_val;

    // Decode the offset and keep only the source bits of the write data.
    assign sel    = decode_ofs(bus_addr);
    assign wd     = bus_wdata[N_SRC-1:0];
    assign wr_hit = bus_sel && bus_wr;

    if (PAD_W > 0) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DATA_W-1:N_SRC];
    end

    // Enable mask changes only through the set and clear offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr_hit && sel == RS_EN_SET) en_q <= en_q | wd;
        else if (wr_hit && sel == RS_EN_CLR) en_q <= en_q & ~wd;
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            pol_q   <= '0;
            tdata_q <= '0;
            tsel_q  <= '0;
        end else if (wr_hit) begin
            if (sel == RS_ROUTE)    route_q <= wd;
            if (sel == RS_POLARITY) pol_q   <= wd;
            if (sel == RS_TDATA)    tdata_q <= wd;
            if (sel == RS_TSEL)     tsel_q  <= wd;
        end
    end

    // Select the source-wide read value for the addressed register.
    always_comb begin
        case (sel)
            RS_PEND_NORM:        rd_val = pend_norm;
            RS_RAW:              rd_val = raw_stat;
            RS_EN_SET, RS_EN_CLR: rd_val = en_q;
            RS_ROUTE:            rd_val = route_q;
            RS_PEND_FAST:        rd_val = pend_fast;
            RS_TDATA:            rd_val = tdata_q;
            RS_TSEL:             rd_val = tsel_q;
            RS_POLARITY:         rd_val = pol_q;
            default:             rd_val = '0;
        endcase
    end

    // Register the read data, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= DATA_W'(rd_val);
    end

    // R3: set-port bits written as 1 are enabled afterwards.
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == RS_EN_SET) |=> ((en_q & $past(wd)) == $past(wd)));

    // R3: set-port bits written as 0 keep their previous enable value.
    assert_set_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == RS_EN_SET) |=> ((en_q & ~$past(wd)) == ($past(en_q) & ~$past(wd))));

    // R4: clear-port bits written as 1 are disabled afterwards.
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == RS_EN_CLR) |=> ((en_q & $past(wd)) == '0));

    // R10: a write to a status offset leaves the enable mask unchanged.
    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (sel == RS_PEND_NORM || sel == RS_RAW || sel == RS_PEND_FAST))
        |=> (en_q == $past(en_q)));

endmodule

// File: rtl/intr_route.sv
// Module: source selection, polarity, masking and routing onto the two request outputs.
// Assumes the synchronised inputs and the configuration are already in the clk domain.
module intr_route #(
    parameter int unsigned N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_src,
    input  logic [N_SRC-1:0] tdata,
    input  logic [N_SRC-1:0] tsel,
    input  logic [N_SRC-1:0] pol,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] route,
    output logic [N_SRC-1:0] raw_stat,
    output logic [N_SRC-1:0] pend_norm,
    output logic [N_SRC-1:0] pend_fast,
    output logic             irq_o,
    output logic             fiq_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Per source: choose the test or real input, then apply the polarity.
        assign raw_stat[i] = (tsel[i] ? tdata[i] : sync_src[i]) ^ pol[i];
    end

    // Mask with the enables and split by the routing bits.
    assign pend_norm = raw_stat & en & ~route;
    assign pend_fast = raw_stat & en &  route;

    // Register the two request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |pend_norm;
            fiq_o <= |pend_fast;
        end
    end

    // R6: with nothing enabled in the previous cycle, both outputs are low.
    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) == '0) |-> (!irq_o && !fiq_o));

    // R5: with every source routed fast in the previous cycle, the normal output is low.
    assert_all_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route) == '1) |-> !irq_o);

    // R5: with every source routed normal in the previous cycle, the fast output is low.
    assert_all_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route) == '0) |-> !fiq_o);

endmodule

// File: rtl/intr_ctrl.sv
// Module: top of the ten-source level interrupt controller.
// Assumes src_i are asynchronous levels and the register bus is synchronous to clk.
module intr_ctrl #(
    parameter int unsigned N_SRC       = 10,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [N_SRC-1:0] sync_src;
    logic [N_SRC-1:0] raw_stat, pend_norm, pend_fast;
    logic [N_SRC-1:0] en_q, route_q, pol_q, tdata_q, tsel_q;

    intr_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_i),
        .dout  (sync_src)
    );

    intr_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .raw_stat  (raw_stat),
        .pend_norm (pend_norm),
        .pend_fast (pend_fast),
        .en_q      (en_q),
        .route_q   (route_q),
        .pol_q     (pol_q),
        .tdata_q   (tdata_q),
        .tsel_q    (tsel_q)
    );

    intr_route #(.N_SRC(N_SRC)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_src  (sync_src),
        .tdata     (tdata_q),
        .tsel      (tsel_q),
        .pol       (pol_q),
        .en        (en_q),
        .route     (route_q),
        .raw_stat  (raw_stat),
        .pend_norm (pend_norm),
        .pend_fast (pend_fast),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

endmodule

// File: tb/sim_intr_ctrl.sv
// Bench: scoreboard bench for intr_ctrl. Read tasks queue expected values; a monitor
// pops them and compares when the read data returns.
module sim_intr_ctrl;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic        rd_pend = 1'b0;

    int nchk = 0;
    int nfail = 0;
    exp_item_t scb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Note that a read was issued at this edge; its data is valid at the next falling edge.
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr && rst_n;

    // Monitor: pop the expected item and compare it with the returned read data.
    always @(negedge clk) begin
        if (rd_pend) begin
            exp_item_t it;
            nchk++;
            if (scb_q.size() == 0) begin
                nfail++;
                $display("FAIL scoreboard: read data with no expected item, actual %h", bus_rdata);
            end else begin
                it = scb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    nfail++;
                    $display("FAIL %s: read @%h actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        scb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_out(input logic ei, input logic ef, input string tag);
        nchk++;
        if (irq_o !== ei || fiq_o !== ef) begin
            nfail++;
            $display("FAIL %s: irq/fiq actual %b%b expected %b%b", tag, irq_o, fiq_o, ei, ef);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        chk_out(1'b0, 1'b0, "R1 outputs in reset");
        rst_n = 1'b1;
        settle();
        chk_out(1'b0, 1'b0, "R1 outputs after reset");
        rd(8'h08, 32'h0, "R1 enable");
        rd(8'h14, 32'h0, "R1 routing");
        rd(8'h24, 32'h0, "R1 polarity");
        rd(8'h20, 32'h0, "R1 test select");
        rd(8'h1C, 32'h0, "R1 test data");
        rd(8'h04, 32'h0, "R1 raw");

        // R3 / R4: set and clear ports.
        wr(8'h08, 32'h005);
        rd(8'h0C, 32'h005, "R4 clear offset reads mask");
        wr(8'h08, 32'h100);
        rd(8'h08, 32'h105, "R3 set keeps zeros");
        wr(8'h0C, 32'h001);
        rd(8'h08, 32'h104, "R4 clear keeps zeros");

        // R2 / R5 / R6: status and outputs.
        @(negedge clk); src_i = 10'h104;
        settle();
        rd(8'h04, 32'h104, "R2 raw follows input");
        rd(8'h00, 32'h104, "R5 normal pending");
        chk_out(1'b1, 1'b0, "R6 normal only");
        wr(8'h14, 32'h100);
        settle();
        rd(8'h00, 32'h004, "R5 normal after routing");
        rd(8'h18, 32'h100, "R5 fast pending");
        chk_out(1'b1, 1'b1, "R6 both outputs");

        // R2: polarity inversion.
        wr(8'h24, 32'h001);
        settle();
        rd(8'h04, 32'h105, "R2 inverted bit 0");
        rd(8'h00, 32'h004, "R2 inverted but disabled");

        // R8: disable and deassert drop the requests.
        wr(8'h0C, 32'h004);
        settle();
        rd(8'h00, 32'h000, "R8 disable clears pending");
        chk_out(1'b0, 1'b1, "R8 normal output drops");
        @(negedge clk); src_i = 10'h000;
        settle();
        rd(8'h18, 32'h000, "R8 deassert clears fast");
        rd(8'h04, 32'h001, "R2 active-low idle reads 1");
        chk_out(1'b0, 1'b0, "R8 fast output drops");

        // R9: synchroniser and output latency.
        wr(8'h24, 32'h000);
        wr(8'h14, 32'h000);
        wr(8'h08, 32'h3FF);
        settle();
        chk_out(1'b0, 1'b0, "R9 idle before edge");
        @(negedge clk); src_i = 10'h020;
        @(negedge clk); chk_out(1'b0, 1'b0, "R9 after 1 edge");
        @(negedge clk); chk_out(1'b0, 1'b0, "R9 after 2 edges");
        @(negedge clk); chk_out(1'b1, 1'b0, "R9 after 3 edges");
        @(negedge clk); src_i = 10'h000;
        settle();

        // R7: test override.
        wr(8'h1C, 32'h002);
        settle();
        rd(8'h04, 32'h000, "R7 test ignored when unselected");
        chk_out(1'b0, 1'b0, "R7 no request from unselected test");
        wr(8'h20, 32'h003);
        @(negedge clk); src_i = 10'h001;
        settle();
        rd(8'h04, 32'h002, "R7 test overrides input");
        chk_out(1'b1, 1'b0, "R7 request from test bit");
        wr(8'h20, 32'h000);
        wr(8'h1C, 32'h000);
        @(negedge clk); src_i = 10'h000;
        settle();

        // R10: unused offsets, read-only offsets, upper bits.
        rd(8'h10, 32'h0, "R10 unused 0x10");
        rd(8'h28, 32'h0, "R10 unused 0x28");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h08, 32'h3FF, "R10 status writes keep enable");
        rd(8'h14, 32'h000, "R10 status writes keep routing");
        wr(8'h14, 32'hFFFF_FC00);
        rd(8'h14, 32'h000, "R10 upper bits dropped");

        repeat (3) @(negedge clk);
        if (scb_q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard: %0d items left, expected 0", scb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule